// File: doc/BRIEF.md
# SDRAM Refresh Scheduler and Interval Timer

This block decides when an SDRAM needs refreshing and hands those refreshes, one at a time, to the command sequencer that actually drives the memory. A free-running divider turns the system clock into a slower count tick, at one of seven selectable ratios or not at all. Each tick advances an interval counter. When the counter equals a programmed constant on a tick, it returns to zero, a sticky match flag is raised, and a group of auto-refreshes is queued. The group size is programmable from one to eight.

Queued refreshes are offered on a request line that stays high until the sequencer acknowledges each one. With refresh disabled, the same counter and flag act as a plain periodic timer with an interrupt output. A pair of inputs moves the memory into and out of self-refresh. While self-refresh is active, no auto-refresh is offered, the counter is frozen, and any queued refreshes are discarded on entry.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `cnt` is 0 and `match_flag`, `irq`, `ref_req` and `sr_active` are all low.
- R2: `clk_sel` values 1 to 7 advance the counter once every 4, 16, 64, 256, 1024, 2048 and 4096 clock cycles respectively. Value 0 stops it.
- R3: On a tick where `cnt` equals `cmp_const`, the counter goes to 0; on any other tick it increments by one, wrapping at its width.
- R4: `match_flag` is set by a compare match and stays set until `flag_clr` is high at a clock edge. A match at the same edge as `flag_clr` leaves it set.
- R5: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R6: With `refresh_en` high, a match queues a number of refreshes given by `burst_sel`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, and 4 to 7 give 8.
- R7: `ref_req` is high whenever refreshes are queued and self-refresh is inactive. Each edge with `ref_req` and `ref_ack` both high removes one queued refresh. `ref_ack` has no effect while `ref_req` is low. A match and an acknowledge at the same edge change the queue by the group size minus one.
- R8: The refresh queue saturates at 15 entries.
- R9: With `refresh_en` low, matches still set `match_flag` but queue no refreshes, so `ref_req` stays low.
- R10: `sr_enter` sets `sr_active` and empties the queue, but is ignored when `sr_exit` is high at the same edge. `sr_exit` clears `sr_active`.
- R11: While `sr_active` is high, `ref_req` is low and `cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Tick divide select (0 stops the counter) |
| cmp_const | input | CNT_W | Compare constant for the interval counter |
| burst_sel | input | 3 | Refreshes queued per match |
| refresh_en | input | 1 | 1: queue refreshes on match; 0: timer only |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the match flag |
| ref_req | output | 1 | Auto-refresh request to the sequencer |
| ref_ack | input | 1 | Sequencer accepted one refresh |
| sr_enter | input | 1 | Enter self-refresh |
| sr_exit | input | 1 | Leave self-refresh |
| sr_active | output | 1 | Self-refresh in effect |
| cnt | output | CNT_W | Current interval count |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The collision of interest is a compare match loading a new refresh group at the same edge that the sequencer acknowledges a queued one. A second collision of the same kind is a match arriving at the same edge as a flag clear. The random phase provokes both. It uses a small compare constant with the fastest divider, acknowledges at random on about half the cycles, and pulses the flag clear often. A cycle-level reference model in the bench, built from the requirements, predicts the queue depth, request line, flag and count, and every cycle is compared against it. The directed group drains whole groups and a saturated queue, and counts the request cycles.

// File: rtl/rfs_pkg.sv
// Package: shared widths and decode functions for the refresh scheduler.
// Assumes: divider width is fixed by the largest ratio (4096).
package rfs_pkg;
    localparam int DIV_W = 12;

    // Low-bit mask of the divider that must be all ones for a tick.
    function automatic logic [DIV_W-1:0] div_mask(input logic [2:0] sel);
        logic [DIV_W-1:0] m;
        case (sel)
            3'd1:    m = 12'h003;
            3'd2:    m = 12'h00F;
            3'd3:    m = 12'h03F;
            3'd4:    m = 12'h0FF;
            3'd5:    m = 12'h3FF;
            3'd6:    m = 12'h7FF;
            3'd7:    m = 12'hFFF;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Number of refreshes queued per compare match.
    function automatic logic [3:0] burst_len(input logic [2:0] sel);
        logic [3:0] n;
        case (sel)
            3'd0:    n = 4'd1;
            3'd1:    n = 4'd2;
            3'd2:    n = 4'd4;
            3'd3:    n = 4'd6;
            default: n = 4'd8;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/rfs_prescaler.sv
// Module: rfs_prescaler
// Free-running divider that emits a one-cycle tick at the selected ratio.
// Assumes: clk_sel may change at any time; a change takes effect on the
// next divider pattern that matches the new mask. Select 0 gives no ticks.
module rfs_prescaler
    import rfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Tick when the selected low bits are all ones.
    always_comb begin
        mask = div_mask(clk_sel);
        tick = (clk_sel != 3'd0) && ((div_q & mask) == mask);
    end
endmodule

// File: rtl/rfs_interval_ctr.sv
// Module: rfs_interval_ctr
// Interval counter: advances on a tick unless held, clears on a compare
// match and reports the match as a single-cycle pulse.
// Assumes: tick is a one-cycle pulse; hold is a registered signal.
module rfs_interval_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] cmp_const,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic adv;

    // Advance qualification and compare.
    always_comb begin
        adv   = tick && !hold;
        match = adv && (cnt == cmp_const);
    end

    // Count register: clear on match, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (match) cnt <= '0;
        else if (adv)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfs_burst_engine.sv
// Module: rfs_burst_engine
// Holds the queue of pending auto-refreshes, offers them one at a time
// over a request/acknowledge pair, and tracks the self-refresh state.
// Assumes: PEND_W >= 4 so a full group of 8 fits in one load.
module rfs_burst_engine
    import rfs_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic       refresh_en,
    input  logic [2:0] burst_sel,
    input  logic       ref_ack,
    input  logic       sr_enter,
    input  logic       sr_exit,
    output logic       ref_req,
    output logic       sr_active
);
    localparam int SUM_W = PEND_W + 2;
    localparam logic [SUM_W-1:0] PEND_MAX = SUM_W'((1 << PEND_W) - 1);

    logic [PEND_W-1:0] pend_q;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  add_v;
    logic [SUM_W-1:0]  sub_v;
    logic              enter_ok;
    logic              exit_ok;

    // Request line and accepted self-refresh transitions.
    always_comb begin
        ref_req  = (pend_q != '0) && !sr_active;
        enter_ok = sr_enter && !sr_active && !sr_exit;
        exit_ok  = sr_exit && sr_active;
    end

    // Next queue depth: load on match, drain on handshake, saturate.
    always_comb begin
        add_v = (match && refresh_en) ? SUM_W'(burst_len(burst_sel)) : '0;
        sub_v = (ref_req && ref_ack) ? SUM_W'(1) : '0;
        sum   = SUM_W'(pend_q) + add_v - sub_v;
        if (sum > PEND_MAX) sum = PEND_MAX;
    end

    // Queue register; emptied on self-refresh entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (enter_ok) pend_q <= '0;
        else               pend_q <= sum[PEND_W-1:0];
    end

    // Self-refresh state.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_active <= 1'b0;
        else if (enter_ok) sr_active <= 1'b1;
        else if (exit_ok)  sr_active <= 1'b0;
    end
endmodule

// File: rtl/refresh_sched.sv
// Module: refresh_sched (top)
// SDRAM refresh scheduler: prescaler, interval counter, sticky match flag
// with interrupt, and the refresh queue with self-refresh control.
// Assumes: all inputs synchronous to clk; sequencer timing is external.
module refresh_sched #(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [CNT_W-1:0] cmp_const,
    input  logic [2:0]       burst_sel,
    input  logic             refresh_en,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             ref_req,
    input  logic             ref_ack,
    input  logic             sr_enter,
    input  logic             sr_exit,
    output logic             sr_active,
    output logic [CNT_W-1:0] cnt,
    output logic             match_flag,
    output logic             irq
);
    logic tick;
    logic match;

    rfs_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    rfs_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold      (sr_active),
        .cmp_const (cmp_const),
        .cnt       (cnt),
        .match     (match)
    );

    rfs_burst_engine #(.PEND_W(PEND_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .refresh_en (refresh_en),
        .burst_sel  (burst_sel),
        .ref_ack    (ref_ack),
        .sr_enter   (sr_enter),
        .sr_exit    (sr_exit),
        .ref_req    (ref_req),
        .sr_active  (sr_active)
    );

    // Sticky match flag; a new match outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (match)    match_flag <= 1'b1;
        else if (flag_clr) match_flag <= 1'b0;
    end

    // Interrupt gating.
    always_comb irq = match_flag && irq_en;
endmodule

// File: rtl/refresh_sched_chk.sv
// Module: refresh_sched_chk
// Temporal checks on the scheduler ports, bound into refresh_sched.
module refresh_sched_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             match_flag,
    input logic             flag_clr,
    input logic             ref_req,
    input logic             ref_ack,
    input logic             sr_active,
    input logic             sr_enter,
    input logic             refresh_en
);
    AST_SR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req); // R11
    AST_SR_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |=> $stable(cnt)); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag); // R4
    AST_REQ_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack && !sr_enter) |=> ref_req); // R7
    AST_TIMER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_en && !ref_req) |=> !ref_req); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)
                  || cnt == '0)); // R3
endmodule

bind refresh_sched refresh_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .match_flag (match_flag),
    .flag_clr   (flag_clr),
    .ref_req    (ref_req),
    .ref_ack    (ref_ack),
    .sr_active  (sr_active),
    .sr_enter   (sr_enter),
    .refresh_en (refresh_en)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] clk_sel = 0;
    logic [7:0] cmp_const = 0;
    logic [2:0] burst_sel = 0;
    logic       refresh_en = 0, irq_en = 0, flag_clr = 0;
    logic       ref_ack = 0, sr_enter = 0, sr_exit = 0;
    logic       ref_req, sr_active, match_flag, irq;
    logic [7:0] cnt;

    int nchk = 0, nerr = 0;
    bit cmp_on = 0;
    bit done = 0;

    refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cmp_const(cmp_const),
        .burst_sel(burst_sel), .refresh_en(refresh_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .ref_req(ref_req), .ref_ack(ref_ack),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .sr_active(sr_active),
        .cnt(cnt), .match_flag(match_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference decodes written from the requirements.
    function automatic int ratio(input int s);
        case (s)
            1: return 4;     2: return 16;    3: return 64;   4: return 256;
            5: return 1024;  6: return 2048;  7: return 4096; default: return 0;
        endcase
    endfunction
    function automatic int glen(input int s);
        case (s)
            0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8;
        endcase
    endfunction

    // Cycle-level reference model.
    int m_div, m_cnt, m_pend;
    bit m_flag, m_sr;
    always @(posedge clk) begin
        bit tk, mt, rq, en_ok, ex_ok;
        int p;
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_pend = 0; m_flag = 0; m_sr = 0;
        end else begin
            tk = (clk_sel != 0) && ((m_div % ratio(clk_sel)) == ratio(clk_sel) - 1);
            mt = tk && !m_sr && (m_cnt == cmp_const);
            rq = (m_pend != 0) && !m_sr;
            en_ok = sr_enter && !m_sr && !sr_exit;
            ex_ok = sr_exit && m_sr;
            if (tk && !m_sr) m_cnt = mt ? 0 : (m_cnt + 1) % 256;
            if (mt) m_flag = 1; else if (flag_clr) m_flag = 0;
            if (en_ok) m_pend = 0;
            else begin
                p = m_pend + ((mt && refresh_en) ? glen(burst_sel) : 0) - ((rq && ref_ack) ? 1 : 0);
                m_pend = (p > 15) ? 15 : p;
            end
            if (en_ok) m_sr = 1; else if (ex_ok) m_sr = 0;
            m_div = (m_div + 1) % 4096;
        end
    end

    // Per-cycle comparison, settled after the negedge input update.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            chk(cnt == m_cnt, "R3 cnt", cnt, m_cnt);
            chk(match_flag == m_flag, "R4 match_flag", match_flag, m_flag);
            chk(irq == (m_flag && irq_en), "R5 irq", irq, m_flag && irq_en);
            chk(ref_req == (m_pend != 0 && !m_sr), "R7 ref_req", ref_req, m_pend != 0 && !m_sr);
            chk(sr_active == m_sr, "R10 sr_active", sr_active, m_sr);
        end
    end

    task automatic pulse_exit();
        sr_exit = 1; @(negedge clk); sr_exit = 0;
    endtask

    // Wait for ref_req to rise, bounded.
    task automatic wait_req();
        int guard = 0;
        while (!ref_req && guard < 3000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        void'($urandom(32'h5EED_0021));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        // R1: reset state
        chk(cnt == 0, "R1 cnt", cnt, 0);
        chk(!match_flag && !irq, "R1 flag/irq", match_flag, 0);
        chk(!ref_req && !sr_active, "R1 req/sr", ref_req, 0);

        // R2: divide ratios and stopped select
        cmp_const = 8'hFF; refresh_en = 0;
        for (int s = 0; s < 8; s++) begin
            int t; logic [7:0] prev;
            clk_sel = s[2:0];
            if (s == 0) begin
                prev = cnt;
                repeat (60) @(negedge clk);
                chk(cnt == prev, "R2 stopped", cnt, prev);
            end else begin
                prev = cnt;
                t = 0;
                while (cnt == prev && t < 5000) begin @(negedge clk); t++; end
                prev = cnt; t = 0;
                while (cnt == prev && t < 5000) begin @(negedge clk); t++; end
                chk(t == ratio(s), "R2 period", t, ratio(s));
            end
        end

        // R6: group sizes, drained and counted
        clk_sel = 0; cmp_const = 0; refresh_en = 1; ref_ack = 0;
        for (int b = 0; b < 8; b++) begin
            int n;
            burst_sel = b[2:0];
            clk_sel = 1;
            wait_req();
            clk_sel = 0;
            ref_ack = 1; n = 0;
            while (ref_req && n < 40) begin @(negedge clk); n++; end
            ref_ack = 0;
            chk(n == glen(b), "R6 group size", n, glen(b));
        end

        // R8: saturation at 15
        burst_sel = 4; clk_sel = 1;
        wait_req();
        repeat (10) @(negedge clk);
        clk_sel = 0;
        begin
            int n = 0;
            ref_ack = 1;
            while (ref_req && n < 40) begin @(negedge clk); n++; end
            ref_ack = 0;
            chk(n == 15, "R8 saturated queue", n, 15);
        end

        // R9: timer mode, ack held high while idle
        refresh_en = 0; flag_clr = 1; @(negedge clk); flag_clr = 0;
        cmp_const = 2; clk_sel = 1; ref_ack = 1;
        begin
            bit seen = 0;
            repeat (40) begin @(negedge clk); if (ref_req) seen = 1; end
            chk(!seen, "R9 no request", seen, 0);
            chk(match_flag, "R9 flag set", match_flag, 1);
        end
        ref_ack = 0; clk_sel = 0;

        // R10 / R11: self-refresh entry, hold, exit
        refresh_en = 1; cmp_const = 1; burst_sel = 3; clk_sel = 1;
        wait_req();
        sr_enter = 1; @(negedge clk); sr_enter = 0;
        chk(sr_active, "R10 entered", sr_active, 1);
        begin
            logic [7:0] held = cnt;
            bit seen = 0;
            repeat (40) begin @(negedge clk); if (ref_req) seen = 1; end
            chk(cnt == held, "R11 count held", cnt, held);
            chk(!seen, "R11 request low", seen, 0);
        end
        sr_enter = 1; sr_exit = 1; @(negedge clk); sr_enter = 0; sr_exit = 0;
        chk(!sr_active, "R10 exit", sr_active, 0);
        sr_enter = 1; sr_exit = 1; @(negedge clk); sr_enter = 0; sr_exit = 0;
        chk(!sr_active, "R10 enter ignored with exit", sr_active, 0);
        clk_sel = 0;

        // Random phase: match/ack and match/clear collisions
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i % 64 == 0) begin
                clk_sel    = ($urandom % 4 == 0) ? 3'd2 : 3'd1;
                cmp_const  = 8'($urandom % 6);
                burst_sel  = 3'($urandom % 8);
                refresh_en = ($urandom % 5 != 0);
            end
            irq_en   = $urandom % 2;
            ref_ack  = $urandom % 2;
            flag_clr = ($urandom % 6 == 0);
            sr_enter = ($urandom % 80 == 0);
            sr_exit  = ($urandom % 30 == 0);
        end
        sr_enter = 0; sr_exit = 0; ref_ack = 0; flag_clr = 0;
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule